// File: doc/BRIEF.md
# Instruction Cache Tag and Lock Controller

This block keeps the tag, valid and lock state of a small direct-mapped instruction cache. It also carries out maintenance commands that software writes through a two-register interface. One register holds a target address. The other takes a command code and reads back the command state and status flags. A privilege input marks whether the writer runs at supervisor level. The commands are unlock one line, unlock every line, enable the cache and disable the cache.

On the fetch side, the block answers hit or miss in the same cycle as the request. A line fill port tells the block when a line arrives from memory, and whether that line should be locked. Each fetch and each fill carries a flag that marks the address as belonging to a region the cache must not hold. Such a line is loaded into a one-line burst buffer instead of the array. Each word of that buffer may be handed out only once before the line must be fetched again.

Top module: `icache_lockctl`

## Requirements
- R1: After reset, every line is invalid and unlocked, the cache is disabled, the burst buffer is empty, the command field reads 0 (idle) and the privilege-error flag is 0. Every fetch misses.
- R2: Command code 1 (unlock line) uses the address register. If the line it names is present, its lock bit is cleared and the line stays valid, so it keeps hitting and can then be replaced by a fill.
- R3: An unlock-line command whose address is not present changes no cache state and raises no error.
- R4: Command code 2 (unlock all) clears every lock bit. Invalid lines stay invalid.
- R5: A command code written to the command field (register select 1, bits [2:0]) reads back for exactly one cycle. It executes at the next clock edge, and the field then reads 0.
- R6: Codes 3 (enable) and 4 (disable), written with the supervisor input high, set or clear the enable flag and clear the privilege-error flag.
- R7: Codes 3 and 4 written with the supervisor input low leave the enable flag unchanged and set the privilege-error flag. Any later accepted command clears the flag.
- R8: While the cache is disabled, every non-inhibited fetch misses and fills allocate no line. Tags, valid bits and lock bits are kept across a disable and enable.
- R9: A fill flagged as inhibited loads the burst buffer and never the cache array.
- R10: An inhibited fetch hits only when its word is in the burst buffer and has not yet been delivered. After a hit, that word misses until the line is filled again. Other words of the line stay available.
- R11: A fill never replaces a locked line that holds a different tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: address register, 1: command field |
| reg_wdata | input | ADDR_W | Write data |
| supervisor | input | 1 | Writer is at supervisor privilege |
| stat_addr | output | ADDR_W | Address register readback |
| stat_cmd | output | 3 | Pending command code, 0 when idle |
| stat_enabled | output | 1 | Cache enable flag |
| stat_priv_err | output | 1 | Last enable/disable was rejected for privilege |
| fill_valid | input | 1 | A line fill arrives this cycle |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_lock | input | 1 | Lock the filled line |
| fill_inhibit | input | 1 | Filled line is from an inhibited region |
| f_req | input | 1 | Fetch request |
| f_addr | input | ADDR_W | Fetch word address |
| f_inhibit | input | 1 | Fetch targets an inhibited region |
| f_hit | output | 1 | Fetch hit, same cycle |
| f_from_buf | output | 1 | Hit was served by the burst buffer |

## Verification
Lock state is not read out directly. A wrong lock bit therefore shows up only at the next fill that tries to replace the line. The lost line then misses, or the new one does, at the first fetch after that fill. Any flaw in the consume-once rule of the burst buffer shows up on the second fetch of the same word. A wrong enable or privilege outcome shows on the status outputs one cycle after the command was written. The bench therefore pairs every maintenance command with a fill and a fetch that reveal the state it changed.

// File: rtl/icache_lockctl.sv
module icache_lockctl #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              supervisor,
  output logic [ADDR_W-1:0] stat_addr,
  output logic [2:0]        stat_cmd,
  output logic              stat_enabled,
  output logic              stat_priv_err,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_lock,
  input  logic              fill_inhibit,
  input  logic              f_req,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_inhibit,
  output logic              f_hit,
  output logic              f_from_buf
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_UNL = 3'd1, OP_UNA = 3'd2,
                         OP_EN = 3'd3, OP_DIS = 3'd4;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q, lock_q;
  logic             en_q, perr_q, cmd_sup_q;
  logic [2:0]       cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic             bb_vld_q;
  logic [LN_W-1:0]  bb_line_q;
  logic [WORDS-1:0] bb_avail_q;

  wire [IDX_W-1:0] f_idx  = f_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] f_tag  = f_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] f_off  = f_addr[OFF_W-1:0];
  wire [IDX_W-1:0] fl_idx = fill_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] fl_tag = fill_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] a_idx  = addr_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0] a_tag  = addr_q[ADDR_W-1 -: TAG_W];

  wire arr_hit = en_q & valid_q[f_idx] & (tag_q[f_idx] == f_tag);
  wire bb_hit  = bb_vld_q & (bb_line_q == f_addr[ADDR_W-1:OFF_W]) & bb_avail_q[f_off];
  wire ul_hit  = valid_q[a_idx] & (tag_q[a_idx] == a_tag);
  wire fill_ok = fill_valid & ~fill_inhibit & en_q &
                 ~(lock_q[fl_idx] & (tag_q[fl_idx] != fl_tag));

  assign f_hit         = f_req & (f_inhibit ? bb_hit : arr_hit);
  assign f_from_buf    = f_req & f_inhibit & bb_hit;
  assign stat_addr     = addr_q;
  assign stat_cmd      = cmd_q;
  assign stat_enabled  = en_q;
  assign stat_priv_err = perr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      if (fill_ok) begin
        valid_q[fl_idx] <= 1'b1;
        lock_q[fl_idx]  <= fill_lock;
        tag_q[fl_idx]   <= fl_tag;
      end
      if (cmd_q == OP_UNA) lock_q <= '0;
      else if (cmd_q == OP_UNL && ul_hit) lock_q[a_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      cmd_q     <= OP_IDLE;
      cmd_sup_q <= 1'b0;
      en_q      <= 1'b0;
      perr_q    <= 1'b0;
    end else begin
      if (reg_we && !reg_sel) addr_q <= reg_wdata;
      if (reg_we && reg_sel) begin
        cmd_q     <= reg_wdata[2:0];
        cmd_sup_q <= supervisor;
      end else begin
        cmd_q <= OP_IDLE;
      end
      case (cmd_q)
        OP_EN, OP_DIS: begin
          if (cmd_sup_q) begin
            en_q   <= (cmd_q == OP_EN);
            perr_q <= 1'b0;
          end else begin
            perr_q <= 1'b1;
          end
        end
        OP_UNL, OP_UNA: perr_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bb_vld_q   <= 1'b0;
      bb_line_q  <= '0;
      bb_avail_q <= '0;
    end else if (fill_valid && fill_inhibit) begin
      bb_vld_q   <= 1'b1;
      bb_line_q  <= fill_addr[ADDR_W-1:OFF_W];
      bb_avail_q <= '1;
    end else if (f_from_buf) begin
      bb_avail_q[f_off] <= 1'b0;
    end
  end
endmodule

// File: rtl/icache_lockctl_chk.sv
module icache_lockctl_chk #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_sel,
  input logic              fill_valid,
  input logic              fill_lock,
  input logic              f_req,
  input logic              f_inhibit,
  input logic [ADDR_W-1:0] f_addr,
  input logic              f_hit,
  input logic [2:0]        stat_cmd,
  input logic              stat_enabled,
  input logic              stat_priv_err,
  input logic              cmd_sup_q,
  input logic [LINES-1:0]  valid_q,
  input logic [LINES-1:0]  lock_q
);
  // R5
  cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_cmd != 3'd0 && !(reg_we && reg_sel)) |=> stat_cmd == 3'd0);

  // R6
  sup_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_cmd == 3'd3 && cmd_sup_q) |=> stat_enabled && !stat_priv_err);

  // R7
  user_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_cmd == 3'd3 || stat_cmd == 3'd4) && !cmd_sup_q) |=> $stable(stat_enabled) && stat_priv_err);

  // R8
  disabled_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_enabled && f_req && !f_inhibit) |-> !f_hit);

  // R4
  unlock_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_cmd == 3'd2 && !(fill_valid && fill_lock)) |=> lock_q == '0);

  // R10
  once_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && f_inhibit && f_hit && !fill_valid) |=>
      !(f_req && f_inhibit && f_addr == $past(f_addr) && f_hit));

  // R1
  always_comb begin
    if (rst_n) begin
      lock_valid_chk: assert ((lock_q & ~valid_q) == '0);
    end
  end
endmodule

bind icache_lockctl icache_lockctl_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .fill_valid(fill_valid), .fill_lock(fill_lock),
  .f_req(f_req), .f_inhibit(f_inhibit), .f_addr(f_addr), .f_hit(f_hit),
  .stat_cmd(stat_cmd), .stat_enabled(stat_enabled), .stat_priv_err(stat_priv_err),
  .cmd_sup_q(cmd_sup_q), .valid_q(valid_q), .lock_q(lock_q)
);

// File: tb/tb_icache_lockctl.sv
module tb_icache_lockctl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_sel = 0, supervisor = 0;
  logic [ADDR_W-1:0] reg_wdata = '0;
  logic [ADDR_W-1:0] stat_addr;
  logic [2:0] stat_cmd;
  logic stat_enabled, stat_priv_err;
  logic fill_valid = 0, fill_lock = 0, fill_inhibit = 0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic f_req = 0, f_inhibit = 0;
  logic [ADDR_W-1:0] f_addr = '0;
  logic f_hit, f_from_buf;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_lockctl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .supervisor(supervisor), .stat_addr(stat_addr),
    .stat_cmd(stat_cmd), .stat_enabled(stat_enabled), .stat_priv_err(stat_priv_err),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_lock(fill_lock),
    .fill_inhibit(fill_inhibit), .f_req(f_req), .f_addr(f_addr),
    .f_inhibit(f_inhibit), .f_hit(f_hit), .f_from_buf(f_from_buf)
  );

  function automatic logic [ADDR_W-1:0] mk(int t, int i, int w);
    return ADDR_W'((t << 5) | (i << 2) | w);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fetch(logic [ADDR_W-1:0] a, logic inh, output logic hit);
    f_req = 1; f_addr = a; f_inhibit = inh;
    #1 hit = f_hit;
    @(negedge clk);
    f_req = 0; f_inhibit = 0;
  endtask

  task automatic fill(logic [ADDR_W-1:0] a, logic lk, logic inh);
    fill_valid = 1; fill_addr = a; fill_lock = lk; fill_inhibit = inh;
    @(negedge clk);
    fill_valid = 0; fill_lock = 0; fill_inhibit = 0;
  endtask

  task automatic set_addr(logic [ADDR_W-1:0] a);
    reg_we = 1; reg_sel = 0; reg_wdata = a;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic cmd(int code, logic sup);
    reg_we = 1; reg_sel = 1; reg_wdata = ADDR_W'(code); supervisor = sup;
    @(negedge clk);
    reg_we = 0; supervisor = 0;
    chk("R5 code visible", int'(stat_cmd), code);
    @(negedge clk);
    chk("R5 back to idle", int'(stat_cmd), 0);
  endtask

  task automatic t_reset;
    logic h;
    chk("R1 cmd idle", int'(stat_cmd), 0);
    chk("R1 disabled", int'(stat_enabled), 0);
    chk("R1 no priv err", int'(stat_priv_err), 0);
    fetch(mk(1, 0, 0), 0, h); chk("R1 array miss", int'(h), 0);
    fetch(mk(1, 0, 0), 1, h); chk("R1 buffer empty", int'(h), 0);
  endtask

  task automatic t_priv;
    cmd(3, 0);
    chk("R7 user enable ignored", int'(stat_enabled), 0);
    chk("R7 priv err set", int'(stat_priv_err), 1);
    cmd(3, 1);
    chk("R6 enabled", int'(stat_enabled), 1);
    chk("R6 R7 err cleared", int'(stat_priv_err), 0);
    cmd(4, 0);
    chk("R7 user disable ignored", int'(stat_enabled), 1);
    chk("R7 priv err set again", int'(stat_priv_err), 1);
    set_addr(mk(30, 7, 0));
    chk("R3 addr readback", int'(stat_addr), int'(mk(30, 7, 0)));
    cmd(1, 0);
    chk("R7 cleared by unlock", int'(stat_priv_err), 0);
  endtask

  task automatic t_lines;
    logic h;
    fill(mk(1, 0, 0), 0, 0);
    fetch(mk(1, 0, 2), 0, h); chk("R11 unlocked fill hits", int'(h), 1);
    fill(mk(2, 0, 0), 0, 0);
    fetch(mk(1, 0, 0), 0, h); chk("R11 unlocked replaced", int'(h), 0);
    fetch(mk(2, 0, 0), 0, h); chk("R11 new tag hits", int'(h), 1);
    fill(mk(1, 0, 0), 1, 0);
    fill(mk(2, 0, 0), 0, 0);
    fetch(mk(2, 0, 0), 0, h); chk("R11 locked not replaced", int'(h), 0);
    fetch(mk(1, 0, 0), 0, h); chk("R11 locked line kept", int'(h), 1);
    set_addr(mk(3, 0, 0));
    cmd(1, 1);
    chk("R3 no error on miss", int'(stat_priv_err), 0);
    fill(mk(2, 0, 0), 0, 0);
    fetch(mk(2, 0, 0), 0, h); chk("R3 lock survives miss unlock", int'(h), 0);
    set_addr(mk(1, 0, 1));
    cmd(1, 1);
    fetch(mk(1, 0, 0), 0, h); chk("R2 still valid after unlock", int'(h), 1);
    fill(mk(2, 0, 0), 0, 0);
    fetch(mk(2, 0, 0), 0, h); chk("R2 unlocked line replaced", int'(h), 1);
    fetch(mk(1, 0, 0), 0, h); chk("R2 old tag gone", int'(h), 0);
  endtask

  task automatic t_unlock_all;
    logic h;
    fill(mk(1, 1, 0), 1, 0);
    fill(mk(1, 2, 0), 1, 0);
    cmd(2, 1);
    fetch(mk(1, 3, 0), 0, h); chk("R4 invalid stays invalid", int'(h), 0);
    fetch(mk(1, 1, 0), 0, h); chk("R4 line still valid", int'(h), 1);
    fill(mk(5, 1, 0), 0, 0);
    fill(mk(5, 2, 0), 0, 0);
    fetch(mk(5, 1, 0), 0, h); chk("R4 line1 unlocked", int'(h), 1);
    fetch(mk(5, 2, 0), 0, h); chk("R4 line2 unlocked", int'(h), 1);
  endtask

  task automatic t_disable;
    logic h;
    fill(mk(1, 4, 0), 1, 0);
    cmd(4, 1);
    chk("R6 disabled", int'(stat_enabled), 0);
    fetch(mk(1, 4, 0), 0, h); chk("R8 disabled miss", int'(h), 0);
    fill(mk(1, 5, 0), 0, 0);
    cmd(3, 1);
    fetch(mk(1, 5, 0), 0, h); chk("R8 no alloc while disabled", int'(h), 0);
    fetch(mk(1, 4, 0), 0, h); chk("R8 line kept", int'(h), 1);
    fill(mk(2, 4, 0), 0, 0);
    fetch(mk(1, 4, 0), 0, h); chk("R8 lock kept", int'(h), 1);
  endtask

  task automatic t_burst;
    logic h;
    fill(mk(7, 6, 0), 0, 1);
    fetch(mk(7, 6, 1), 0, h); chk("R9 not in array", int'(h), 0);
    fetch(mk(7, 6, 1), 1, h); chk("R10 first delivery", int'(h), 1);
    fetch(mk(7, 6, 1), 1, h); chk("R10 second delivery miss", int'(h), 0);
    f_req = 1; f_addr = mk(7, 6, 2); f_inhibit = 1;
    #1 chk("R10 buffer source", int'(f_from_buf), 1);
    @(negedge clk); f_req = 0; f_inhibit = 0;
    fetch(mk(7, 6, 2), 1, h); chk("R10 word2 consumed", int'(h), 0);
    fetch(mk(7, 6, 3), 1, h); chk("R10 word3 available", int'(h), 1);
    fetch(mk(8, 6, 0), 1, h); chk("R10 other line miss", int'(h), 0);
    fill(mk(7, 6, 0), 0, 1);
    fetch(mk(7, 6, 1), 1, h); chk("R10 refetch restores", int'(h), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_priv();
    t_lines();
    t_unlock_all();
    t_disable();
    t_burst();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule